// File: doc/BRIEF.md
# RTC Register Target on a Two-Wire Bus

This block is the two-wire serial (I2C) target side of a real-time clock. It watches the clock and data lines, which are sampled into the system clock domain. When its own 7-bit device address appears, it answers. A write sets a register pointer with its first data byte, and each later byte goes to the register the pointer selects. A read returns bytes starting at the pointer. The pointer advances by one after every byte in either direction and wraps at the end of the register file. A repeated START keeps the pointer, so a pointer write followed by a repeated START and a read fetches any register. The data line is modelled as an open-drain pull-down enable.

The register file holds seconds (register 0), minutes (register 1) and hours (register 2), plus general scratch registers. A once-per-second tick advances the time of day. For the whole time a transaction is open, the time-of-day registers are frozen so that a multi-byte read is coherent. Ticks that arrive during that window are counted, and they are applied one per clock cycle once the transaction closes, so no second is lost. The same tick drives a watchdog over the whole START-to-STOP window, repeated STARTs included. When the watchdog expires, the interface returns to idle with the data line released.

Top module: `i2cr_rtc_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 0110010 (bit 0 is read=1/write=0). On any other address it never pulls SDA low until the next START.
- R2: In a write, the first data byte loads the register pointer (its low bits). Each following byte is stored at the pointer, and the pointer then increments, wrapping from the last register to register 0.
- R3: In a read, the register at the pointer is shifted out MSB first, and the pointer increments after each byte. A master ACK (SDA low on the 9th clock) continues with the next register. A NACK ends the read with SDA released.
- R4: A repeated START restarts address decoding without changing the pointer. It does not restart the transaction watchdog.
- R5: After the 8th falling SCL edge of an acknowledged address byte or written byte, SDA is pulled low. It is released at the falling SCL edge that ends the 9th clock.
- R6: The block changes its SDA drive only while SCL is low.
- R7: Once TMO_TICKS ticks have arrived since the START that opened a transaction, the interface returns to idle and releases SDA. It ignores the bus until the next START.
- R8: A STOP at any point, including mid-byte, returns the interface to idle with SDA released. A partially received byte is not stored.
- R9: Each tick advances seconds 0–59, carries into minutes 0–59 and then into hours 0–23, and the time wraps from 23:59:59 to 00:00:00.
- R10: While a transaction is open, the time-of-day registers do not advance. Ticks received in that window are all applied after it closes, whether it closed by STOP or by timeout.
- R11: After reset, SDA is released, the interface is idle, and all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| tick_i | input | 1 | One-cycle pulse per second for timekeeping and watchdog |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
The assertions check several rules on every cycle. They confirm that the SDA drive moves only in a cycle that follows a low SCL sample (outside a timeout). They check that a STOP or a watchdog expiry leaves the line released with the transaction closed. They check that the time registers hold steady whenever a transaction is open, and that the pending-tick count rises for each tick during an access and falls by one per cycle after it. Only the bench scenarios can show the protocol outcomes: address matching, pointer loading and wrap, auto-increment across repeated STARTs, ACK placement, the carry chain through 23:59:59, and the exact number of seconds recovered after a frozen access or a watchdog expiry.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } bus_st_t;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
  } tod_t;

  // one-second advance of the time of day with carries
  function automatic tod_t tod_step(tod_t t);
    tod_t n;
    n = t;
    if (t.sec >= 8'd59) begin
      n.sec = 8'd0;
      if (t.min >= 8'd59) begin
        n.min = 8'd0;
        n.hr  = (t.hr >= 8'd23) ? 8'd0 : t.hr + 8'd1;
      end else begin
        n.min = t.min + 8'd1;
      end
    end else begin
      n.sec = t.sec + 8'd1;
    end
    return n;
  endfunction

  function automatic logic addr_hit(logic [6:0] rx, logic [6:0] own);
    return rx == own;
  endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_prev = sda_sh[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cr_watchdog.sv
module i2cr_watchdog #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic xfer_open,
  output logic fire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!xfer_open) cnt <= '0;
    else if (tick)       cnt <= cnt + 1'b1;
  end

  assign fire = xfer_open && tick && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/i2cr_bus_fsm.sv
module i2cr_bus_fsm
  import i2cr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0110010,
  parameter int         AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          tmo_fire,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          xfer_open,
  output logic          sda_pull
);
  bus_st_t       st;
  logic [3:0]    cnt;
  logic [7:0]    rxb, txb;
  logic [AW-1:0] ptr;
  logic          rw, first, acked;

  assign rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; rxb <= '0; txb <= '0; ptr <= '0;
      rw <= 1'b0; first <= 1'b0; acked <= 1'b0;
      sda_pull <= 1'b0; xfer_open <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (tmo_fire) begin
        st <= ST_IDLE; sda_pull <= 1'b0; xfer_open <= 1'b0;
      end else if (start_evt) begin
        st <= ST_ADDR; cnt <= '0; sda_pull <= 1'b0; xfer_open <= 1'b1;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_pull <= 1'b0; xfer_open <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              rxb <= {rxb[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (addr_hit(rxb[7:1], DEV_ADDR)) begin
                rw <= rxb[0]; sda_pull <= 1'b1; st <= ST_ADDR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                sda_pull <= ~rd_data[7];
                txb <= {rd_data[6:0], 1'b0};
                cnt <= 4'd1;
                st  <= ST_RD;
              end else begin
                sda_pull <= 1'b0; first <= 1'b1; cnt <= '0; st <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rxb <= {rxb[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0; sda_pull <= 1'b1; st <= ST_WR_ACK;
              if (first) begin
                ptr <= rxb[AW-1:0]; first <= 1'b0;
              end else begin
                wr_en <= 1'b1; wr_addr <= ptr; wr_data <= rxb;
                ptr <= ptr + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0; st <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0; ptr <= ptr + 1'b1; st <= ST_RD_ACK;
              end else begin
                sda_pull <= ~txb[7];
                txb <= {txb[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              acked <= ~sda_lvl;
            end else if (scl_fall) begin
              if (acked) begin
                sda_pull <= ~rd_data[7];
                txb <= {rd_data[6:0], 1'b0};
                cnt <= 4'd1;
                st  <= ST_RD;
              end else begin
                sda_pull <= 1'b0; st <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile
  import i2cr_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int AW     = 3,
  parameter int PEND_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          frozen,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam logic [PEND_W-1:0] PMAX = '1;

  logic [7:0]        cell_q [NREG];
  logic [PEND_W-1:0] pend;
  logic              apply, inc;
  tod_t              cur_tod, nxt_tod;

  assign cur_tod = '{sec: cell_q[0], min: cell_q[1], hr: cell_q[2]};
  assign nxt_tod = tod_step(cur_tod);
  assign apply   = !frozen && (pend != '0);
  assign inc     = tick && ((pend != PMAX) || apply);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend + PEND_W'(inc) - PEND_W'(apply);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    logic [7:0] q, adv;
    if (i == 0) begin : g_s
      assign adv = nxt_tod.sec;
    end else if (i == 1) begin : g_m
      assign adv = nxt_tod.min;
    end else if (i == 2) begin : g_h
      assign adv = nxt_tod.hr;
    end else begin : g_x
      assign adv = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               q <= '0;
      else if (wr_en && wr_addr == AW'(i))      q <= wr_data;
      else if (apply)                           q <= adv;
    end
    assign cell_q[i] = q;
  end

  assign rd_data = cell_q[rd_addr];

  // time of day holds during an open transaction unless the bus writes it
  assert_tod_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !wr_en) |=> $stable(cur_tod));
  // a tick during an access is remembered
  assert_tick_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && tick && pend != PMAX) |=> (pend == $past(pend) + 1'b1));
  // held ticks drain one per cycle after the access
  assert_pend_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && pend != '0 && !tick) |=> (pend + 1'b1 == $past(pend)));
endmodule

// File: rtl/i2cr_rtc_target.sv
module i2cr_rtc_target #(
  parameter logic [6:0] DEV_ADDR    = 7'b0110010,
  parameter int         NREG        = 8,
  parameter int         TMO_TICKS   = 2,
  parameter int         PEND_W      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic tick_i,
  output logic sda_pull_o
);
  localparam int AW = $clog2(NREG);

  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic          tmo_fire, xfer_open, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_lvl, .sda_lvl, .scl_rise, .scl_fall, .start_evt, .stop_evt
  );

  i2cr_watchdog #(.LIMIT(TMO_TICKS)) u_wdog (
    .clk, .rst_n, .tick(tick_i), .xfer_open, .fire(tmo_fire)
  );

  i2cr_bus_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk, .rst_n, .scl_rise, .scl_fall, .sda_lvl, .start_evt, .stop_evt,
    .tmo_fire, .rd_data, .rd_addr, .wr_en, .wr_addr, .wr_data,
    .xfer_open, .sda_pull(sda_pull_o)
  );

  i2cr_regfile #(.NREG(NREG), .AW(AW), .PEND_W(PEND_W)) u_regs (
    .clk, .rst_n, .tick(tick_i), .frozen(xfer_open), .wr_en, .wr_addr,
    .wr_data, .rd_addr, .rd_data
  );

  assert_sda_moves_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(tmo_fire)) |-> !$past(scl_lvl));
  assert_timeout_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (!sda_pull_o && !xfer_open));
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt && !tmo_fire) |=> (!sda_pull_o && !xfer_open));
endmodule

// File: tb/sim_i2cr_rtc_target.sv
module sim_i2cr_rtc_target;
  localparam int H = 16;
  localparam logic [7:0] AW_ = 8'h64;  // address, write
  localparam logic [7:0] AR_ = 8'h65;  // address, read
  localparam logic [15:0] VEC [6] = '{16'h03A5, 16'h043C, 16'h0500,
                                      16'h06FF, 16'h0781, 16'h012A};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, tick = 1'b0;
  logic sda_pull, sda_bus;
  int n_chk = 0, n_bad = 0, r6_viol = 0;
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  assign sda_bus = m_sda & ~sda_pull;
  always #10 clk = ~clk;

  i2cr_rtc_target #(.TMO_TICKS(4)) u0 (
    .clk, .rst_n, .scl_i(m_scl), .sda_i(sda_bus), .tick_i(tick),
    .sda_pull_o(sda_pull)
  );

  // R6 monitor: drive must not change while SCL stays high
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_pull != prev_pull) r6_viol++;
    prev_scl  <= m_scl;
    prev_pull <= sda_pull;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic s);
    m_sda = b; w(H);
    m_scl = 1'b1; w(H/2);
    s = sda_bus; w(H/2);
    m_scl = 1'b0; w(H/2);
  endtask

  task automatic bus_start();
    if (!m_scl) begin
      m_sda = 1'b1; w(H); m_scl = 1'b1; w(H);
    end
    m_sda = 1'b0; w(H);
    m_scl = 1'b0; w(H/2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(H);
    m_scl = 1'b1; w(H);
    m_sda = 1'b1; w(H);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(d[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, s);
      d = {d[6:0], s};
    end
    bit_x(~mack, s);
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [7:0] d);
    logic a;
    bus_start(); wbyte(AW_, a); wbyte(p, a); wbyte(d, a); bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d);
    logic a;
    bus_start(); wbyte(AW_, a); wbyte(p, a);
    bus_start(); wbyte(AR_, a); rbyte(1'b0, d); bus_stop();
  endtask

  task automatic pulse_tick();
    tick = 1'b1; w(1); tick = 1'b0; w(3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    w(200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    logic [7:0] d, d2, d3;
    logic a, s;
    w(5); rst_n = 1'b1; w(5);

    // R11 reset state
    check("R11 sda released", sda_pull, 1'b0);
    read_reg(8'd0, d); check("R11 sec", d, 8'h00);
    read_reg(8'd2, d); check("R11 hour", d, 8'h00);
    read_reg(8'd5, d); check("R11 scratch", d, 8'h00);

    // R2/R3 vector table: write then read back
    for (int i = 0; i < 6; i++) begin
      write_reg(VEC[i][15:8], VEC[i][7:0]);
      read_reg(VEC[i][15:8], d);
      check("R2 R3 readback", d, VEC[i][7:0]);
    end

    // R1 address matching
    bus_start(); wbyte(AW_, a); check("R1 own address acked", a, 1'b1);
    wbyte(8'd3, a); bus_stop();
    bus_start(); wbyte(8'h66, a); check("R1 foreign address not acked", a, 1'b0);
    wbyte(8'h00, a); check("R1 no ack after mismatch", a, 1'b0);
    bus_stop();
    bus_start(); wbyte(8'h67, a); rbyte(1'b1, d);
    check("R1 no data driven after mismatch", d, 8'hFF);
    bus_stop();

    // R5 acknowledge window
    bus_start();
    for (int i = 7; i >= 0; i--) bit_x(AW_[i], s);
    w(4); check("R5 ack driven after 8th fall", sda_pull, 1'b1);
    bit_x(1'b1, s); check("R5 ack low on 9th clock", s, 1'b0);
    w(4); check("R5 released after 9th fall", sda_pull, 1'b0);
    bus_stop();

    // R2 multi-byte write with wrap, R3 multi-byte read
    bus_start(); wbyte(AW_, a); wbyte(8'd6, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); bus_stop();
    bus_start(); wbyte(AW_, a); wbyte(8'd6, a);
    bus_start(); wbyte(AR_, a);
    rbyte(1'b1, d); rbyte(1'b1, d2); rbyte(1'b0, d3);
    w(4); check("R3 released after nack", sda_pull, 1'b0);
    bus_stop();
    check("R2 R3 reg6", d, 8'h11);
    check("R2 R3 reg7", d2, 8'h22);
    check("R2 wrap to reg0", d3, 8'h33);

    // R4 pointer survives repeated starts
    bus_start(); wbyte(AW_, a); wbyte(8'd3, a);
    bus_start(); wbyte(AR_, a); rbyte(1'b0, d);
    bus_start(); wbyte(AR_, a); rbyte(1'b0, d2); bus_stop();
    check("R4 first read reg3", d, 8'hA5);
    check("R4 second read reg4", d2, 8'h3C);

    // R9 carry chain
    bus_start(); wbyte(AW_, a); wbyte(8'd0, a);
    wbyte(8'd59, a); wbyte(8'd59, a); wbyte(8'd23, a); bus_stop();
    w(4); pulse_tick(); w(4);
    bus_start(); wbyte(AW_, a); wbyte(8'd0, a);
    bus_start(); wbyte(AR_, a);
    rbyte(1'b1, d); rbyte(1'b1, d2); rbyte(1'b0, d3); bus_stop();
    check("R9 wrap sec", d, 8'd0);
    check("R9 wrap min", d2, 8'd0);
    check("R9 wrap hour", d3, 8'd0);
    bus_start(); wbyte(AW_, a); wbyte(8'd0, a);
    wbyte(8'd59, a); wbyte(8'd5, a); wbyte(8'd7, a); bus_stop();
    w(4); pulse_tick(); w(4);
    read_reg(8'd1, d); check("R9 minute carry", d, 8'd6);
    read_reg(8'd2, d); check("R9 hour kept", d, 8'd7);

    // R10 freeze during an access, ticks applied after
    write_reg(8'd0, 8'd10);
    bus_start(); wbyte(AW_, a); wbyte(8'd0, a);
    pulse_tick(); pulse_tick(); pulse_tick();
    bus_start(); wbyte(AR_, a); rbyte(1'b0, d); bus_stop();
    check("R10 frozen sec during access", d, 8'd10);
    w(10);
    read_reg(8'd0, d); check("R10 held ticks applied", d, 8'd13);

    // R7 timeout across a repeated start (R4 watchdog not restarted)
    bus_start(); wbyte(AW_, a); wbyte(8'd5, a);
    pulse_tick(); pulse_tick(); pulse_tick();
    bus_start(); wbyte(AR_, a);
    w(4); check("R7 slave driving before timeout", sda_pull, 1'b1);
    pulse_tick();
    w(4); check("R7 released on timeout", sda_pull, 1'b0);
    rbyte(1'b1, d); check("R7 bus ignored after timeout", d, 8'hFF);
    bus_stop();
    w(10);
    read_reg(8'd0, d); check("R10 ticks kept through timeout", d, 8'd17);

    // R8 stop mid-byte
    bus_start(); wbyte(AW_, a); wbyte(8'd3, a);
    for (int i = 0; i < 4; i++) bit_x(1'b0, s);
    bus_stop();
    check("R8 released after stop", sda_pull, 1'b0);
    read_reg(8'd3, d); check("R8 partial byte not stored", d, 8'hA5);

    check("R6 drive changed with SCL high", r6_viol, 0);
    summary();
  end
endmodule